// File: doc/BRIEF.md
# Vector Core Register Scoreboard and Issue Stage

This block sits between instruction decode and the execution units of a vector core. Each cycle it may take one decoded instruction. The decoder supplies the instruction as fields: a queue code, a compute-unit code, and one-hot-per-register masks of every scalar and vector register the instruction names. The block steers the instruction into one of three in-order issue queues: vector compute, vector memory or scalar.

A register scoreboard holds one busy bit per scalar register and one per vector register. A single bit covers both reads and writes. An instruction is admitted only when its queue has room and none of the registers it names is busy. When it is not admitted, fetch and decode are told to hold. A halt instruction is never queued and freezes fetch for good.

Each queue issues on its own, so up to three instructions can leave in one cycle. A vector compute head leaves when its unit (add, multiply, divide or permute) is free. A memory head leaves when the memory unit is free. A scalar head leaves whenever one is present. The block records which units are occupied and which registers each one holds. When a unit pulses completion, the block frees that unit and clears its registers.

Top module: `vec_issue_sb`

## Requirements
- R1: After reset every busy bit is clear, all queues are empty, no unit is occupied, `idle_o` is 1 and `halted_o` is 0.
- R2: Queue code 0 selects the vector compute queue, 1 the vector memory queue and 2 the scalar queue. Code 3 is refused (`dec_accept_o` low).
- R3: An instruction is refused while its queue already holds its depth limit: `CMP_DEPTH` for the compute and scalar queues, `MEM_DEPTH` for the memory queue. A full queue does not block admission to another queue.
- R4: An instruction that names any busy register is refused, with `fetch_hold_o` high in the same cycle. The busy bits are left unchanged.
- R5: On admission, the busy bit of every register named in `dec_sregs_i` and `dec_vregs_i` is set from the next cycle.
- R6: The compute queue head issues (`vc_issue_o`, unit code on `vc_unit_o`: 0 add, 1 multiply, 2 divide, 3 permute) only while that unit is unoccupied. Later entries wait behind it.
- R7: The memory queue head issues (`vm_issue_o`) only while the memory unit is unoccupied.
- R8: A scalar head issues in the cycle after it is queued, and its busy bits are clear from the cycle after it issues.
- R9: Busy bits held by a vector unit clear in the cycle after its completion bit on `unit_done_i` is high. The bits are 0 add, 1 multiply, 2 divide, 3 permute, 4 memory. A completion bit for an unoccupied unit has no effect.
- R10: The compute, memory and scalar queues can each issue in the same cycle.
- R11: A halt instruction is refused and raises `fetch_hold_o`. `halted_o` rises in the next cycle and stays high until reset. While halted, every instruction is refused.
- R12: `idle_o` is high exactly when all queues are empty, no unit is occupied and no busy bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A decoded instruction is offered |
| dec_halt_i | input | 1 | Offered instruction is a halt |
| dec_queue_i | input | 2 | Queue code |
| dec_unit_i | input | 2 | Compute unit code for compute-queue instructions |
| dec_sregs_i | input | 8 | Mask of scalar registers named |
| dec_vregs_i | input | 8 | Mask of vector registers named |
| dec_accept_o | output | 1 | Instruction admitted this cycle |
| fetch_hold_o | output | 1 | Fetch and decode must hold |
| halted_o | output | 1 | A halt has been seen |
| vc_issue_o | output | 1 | Compute queue head issues |
| vc_unit_o | output | 2 | Unit of the issuing compute instruction |
| vm_issue_o | output | 1 | Memory queue head issues |
| sc_issue_o | output | 1 | Scalar queue head issues |
| unit_done_i | input | 5 | Per-unit completion pulses |
| sreg_busy_o | output | 8 | Scalar busy bits |
| vreg_busy_o | output | 8 | Vector busy bits |
| idle_o | output | 1 | Nothing queued, occupied or busy |

## Verification
The bench fills the memory and compute queues to their limits while their units are held occupied. It then checks that the next instruction is refused, which catches an off-by-one depth compare that would admit one too many or stall one early. It releases the adder and the memory unit in the same cycle that a scalar instruction arrives. This targets a design that issues from a single shared port, which would show fewer than three issues. A completion pulse on an idle unit would, in a design that fails to gate completions, wipe out registers held by another unit. A compute entry queued behind a busy adder must not slip out early, and a halt must stay in force for the rest of the run.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int NUM_SREG  = 8;
  localparam int NUM_VREG  = 8;
  localparam int NUM_UNITS = 5;
  localparam int MEM_UNIT  = 4;

  typedef enum logic [1:0] {Q_VCMP = 2'd0, Q_VMEM = 2'd1, Q_SCL = 2'd2} queue_e;
  typedef enum logic [1:0] {U_ADD = 2'd0, U_MUL = 2'd1, U_DIV = 2'd2, U_PERM = 2'd3} unit_e;

  typedef struct packed {
    unit_e               unit;
    logic [NUM_SREG-1:0] s;
    logic [NUM_VREG-1:0] v;
  } vc_ent_t;

  typedef struct packed {
    logic [NUM_SREG-1:0] s;
    logic [NUM_VREG-1:0] v;
  } rs_ent_t;
endpackage

// File: rtl/vis_fifo.sv
module vis_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/vis_unit_track.sv
module vis_unit_track
  import vis_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_UNITS-1:0]                 start_i,
  input  logic [NUM_UNITS-1:0][NUM_SREG-1:0]   start_s_i,
  input  logic [NUM_UNITS-1:0][NUM_VREG-1:0]   start_v_i,
  input  logic [NUM_UNITS-1:0]                 done_i,
  output logic [NUM_UNITS-1:0]                 occ_o,
  output logic [NUM_SREG-1:0]                  clr_s_o,
  output logic [NUM_VREG-1:0]                  clr_v_o
);
  logic [NUM_UNITS-1:0]               occ_q;
  logic [NUM_UNITS-1:0]               fin;
  logic [NUM_UNITS-1:0][NUM_SREG-1:0] hold_s_q;
  logic [NUM_UNITS-1:0][NUM_VREG-1:0] hold_v_q;

  // completion only counts for a unit that holds an instruction
  assign fin   = done_i & occ_q;
  assign occ_o = occ_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[u]    <= 1'b0;
        hold_s_q[u] <= '0;
        hold_v_q[u] <= '0;
      end else if (start_i[u]) begin
        occ_q[u]    <= 1'b1;
        hold_s_q[u] <= start_s_i[u];
        hold_v_q[u] <= start_v_i[u];
      end else if (fin[u]) begin
        occ_q[u]    <= 1'b0;
        hold_s_q[u] <= '0;
        hold_v_q[u] <= '0;
      end
    end

    AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[u] |-> !occ_q[u]); // R6
  end

  always_comb begin
    clr_s_o = '0;
    clr_v_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (fin[u]) begin
        clr_s_o |= hold_s_q[u];
        clr_v_o |= hold_v_q[u];
      end
    end
  end
endmodule

// File: rtl/vis_busy_board.sv
module vis_busy_board #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] busy_o
);
  logic [N-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~clr_i) | set_i;
  end

  assign busy_o = busy_q;

  AST_CLR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~busy_q) == '0); // R9
  AST_SET_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & busy_q) == '0); // R4
endmodule

// File: rtl/vec_issue_sb.sv
module vec_issue_sb
  import vis_pkg::*;
#(
  parameter int CMP_DEPTH = 4,
  parameter int MEM_DEPTH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dec_valid_i,
  input  logic                 dec_halt_i,
  input  logic [1:0]           dec_queue_i,
  input  logic [1:0]           dec_unit_i,
  input  logic [NUM_SREG-1:0]  dec_sregs_i,
  input  logic [NUM_VREG-1:0]  dec_vregs_i,
  output logic                 dec_accept_o,
  output logic                 fetch_hold_o,
  output logic                 halted_o,
  output logic                 vc_issue_o,
  output logic [1:0]           vc_unit_o,
  output logic                 vm_issue_o,
  output logic                 sc_issue_o,
  input  logic [NUM_UNITS-1:0] unit_done_i,
  output logic [NUM_SREG-1:0]  sreg_busy_o,
  output logic [NUM_VREG-1:0]  vreg_busy_o,
  output logic                 idle_o
);
  localparam int VC_W = $bits(vc_ent_t);
  localparam int RS_W = $bits(rs_ent_t);

  logic    halted_q, q_room, hazard, accept;
  logic    vc_empty, vc_full, vm_empty, vm_full, sc_empty, sc_full;
  vc_ent_t vc_in, vc_head;
  rs_ent_t rs_in, vm_head, sc_head;
  logic    [NUM_UNITS-1:0] occ, start;
  logic    [NUM_UNITS-1:0][NUM_SREG-1:0] st_s;
  logic    [NUM_UNITS-1:0][NUM_VREG-1:0] st_v;
  logic    [NUM_SREG-1:0] u_clr_s, s_set, s_clr;
  logic    [NUM_VREG-1:0] u_clr_v, v_set, v_clr;

  always_comb begin
    case (queue_e'(dec_queue_i))
      Q_VCMP:  q_room = !vc_full;
      Q_VMEM:  q_room = !vm_full;
      Q_SCL:   q_room = !sc_full;
      default: q_room = 1'b0;
    endcase
  end

  assign hazard       = |(dec_sregs_i & sreg_busy_o) | |(dec_vregs_i & vreg_busy_o);
  assign accept       = dec_valid_i && !dec_halt_i && !halted_q && q_room && !hazard;
  assign dec_accept_o = accept;
  assign fetch_hold_o = halted_q || (dec_valid_i && !accept);
  assign halted_o     = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         halted_q <= 1'b0;
    else if (dec_valid_i && dec_halt_i)  halted_q <= 1'b1;
  end

  assign vc_in = '{unit: unit_e'(dec_unit_i), s: dec_sregs_i, v: dec_vregs_i};
  assign rs_in = '{s: dec_sregs_i, v: dec_vregs_i};

  assign vc_issue_o = !vc_empty && !occ[vc_head.unit];
  assign vc_unit_o  = vc_head.unit;
  assign vm_issue_o = !vm_empty && !occ[MEM_UNIT];
  assign sc_issue_o = !sc_empty;

  vis_fifo #(.DEPTH(CMP_DEPTH), .W(VC_W)) u_vc_q (
    .clk_i, .rst_ni,
    .push_i (accept && dec_queue_i == Q_VCMP),
    .data_i (vc_in),
    .pop_i  (vc_issue_o),
    .head_o (vc_head),
    .empty_o(vc_empty),
    .full_o (vc_full)
  );

  vis_fifo #(.DEPTH(MEM_DEPTH), .W(RS_W)) u_vm_q (
    .clk_i, .rst_ni,
    .push_i (accept && dec_queue_i == Q_VMEM),
    .data_i (rs_in),
    .pop_i  (vm_issue_o),
    .head_o (vm_head),
    .empty_o(vm_empty),
    .full_o (vm_full)
  );

  // scalar queue reuses the compute depth limit
  vis_fifo #(.DEPTH(CMP_DEPTH), .W(RS_W)) u_sc_q (
    .clk_i, .rst_ni,
    .push_i (accept && dec_queue_i == Q_SCL),
    .data_i (rs_in),
    .pop_i  (sc_issue_o),
    .head_o (sc_head),
    .empty_o(sc_empty),
    .full_o (sc_full)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_start
    if (u == MEM_UNIT) begin : g_mem
      assign start[u] = vm_issue_o;
      assign st_s[u]  = vm_head.s;
      assign st_v[u]  = vm_head.v;
    end else begin : g_cmp
      assign start[u] = vc_issue_o && (vc_head.unit == unit_e'(u));
      assign st_s[u]  = vc_head.s;
      assign st_v[u]  = vc_head.v;
    end
  end

  vis_unit_track u_track (
    .clk_i, .rst_ni,
    .start_i  (start),
    .start_s_i(st_s),
    .start_v_i(st_v),
    .done_i   (unit_done_i),
    .occ_o    (occ),
    .clr_s_o  (u_clr_s),
    .clr_v_o  (u_clr_v)
  );

  assign s_set = accept ? dec_sregs_i : '0;
  assign v_set = accept ? dec_vregs_i : '0;
  assign s_clr = u_clr_s | (sc_issue_o ? sc_head.s : '0);
  assign v_clr = u_clr_v | (sc_issue_o ? sc_head.v : '0);

  vis_busy_board #(.N(NUM_SREG)) u_sbusy (
    .clk_i, .rst_ni, .set_i(s_set), .clr_i(s_clr), .busy_o(sreg_busy_o)
  );

  vis_busy_board #(.N(NUM_VREG)) u_vbusy (
    .clk_i, .rst_ni, .set_i(v_set), .clr_i(v_clr), .busy_o(vreg_busy_o)
  );

  assign idle_o = vc_empty && vm_empty && sc_empty && (occ == '0)
                  && (sreg_busy_o == '0) && (vreg_busy_o == '0);

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((sreg_busy_o & $past(dec_sregs_i)) == $past(dec_sregs_i))
            && ((vreg_busy_o & $past(dec_vregs_i)) == $past(dec_vregs_i))); // R5
  AST_SCL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_issue_o |=> (sreg_busy_o & $past(sc_head.s)) == '0); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R11
  AST_HALT_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !dec_accept_o); // R11
endmodule

// File: tb/tb_vec_issue_sb.sv
module tb_vec_issue_sb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_halt = 1'b0;
  logic [1:0] dec_queue = '0, dec_unit = '0;
  logic [7:0] dec_sregs = '0, dec_vregs = '0;
  logic [4:0] unit_done = '0;
  logic dec_accept, fetch_hold, halted, vc_issue, vm_issue, sc_issue, idle;
  logic [1:0] vc_unit;
  logic [7:0] sreg_busy, vreg_busy;

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic acc, hold;

  always #2.5 clk = ~clk;

  vec_issue_sb dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dec_valid), .dec_halt_i(dec_halt), .dec_queue_i(dec_queue),
    .dec_unit_i(dec_unit), .dec_sregs_i(dec_sregs), .dec_vregs_i(dec_vregs),
    .dec_accept_o(dec_accept), .fetch_hold_o(fetch_hold), .halted_o(halted),
    .vc_issue_o(vc_issue), .vc_unit_o(vc_unit), .vm_issue_o(vm_issue),
    .sc_issue_o(sc_issue), .unit_done_i(unit_done),
    .sreg_busy_o(sreg_busy), .vreg_busy_o(vreg_busy), .idle_o(idle)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer one instruction for one cycle; returns at the following negedge
  task automatic send(input logic [1:0] q, input logic [1:0] u,
                      input logic [7:0] s, input logic [7:0] v, input logic h);
    @(negedge clk);
    dec_valid = 1'b1; dec_queue = q; dec_unit = u;
    dec_sregs = s; dec_vregs = v; dec_halt = h;
    #1;
    acc = dec_accept; hold = fetch_hold;
    @(negedge clk);
    dec_valid = 1'b0; dec_halt = 1'b0; dec_sregs = '0; dec_vregs = '0;
  endtask

  task automatic pulse(input logic [4:0] d);
    @(negedge clk);
    unit_done = d;
    @(negedge clk);
    unit_done = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && !idle; i++) pulse(5'h1F);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 busy", {sreg_busy, vreg_busy}, 16'h0);
    chk("R1 idle", idle, 1);
    chk("R1 halted", halted, 0);
    chk("R1 issues", {vc_issue, vm_issue, sc_issue}, 3'b000);
  endtask

  task automatic t_scalar();
    send(2'd2, 2'd0, 8'h03, 8'h00, 0);
    chk("R2 scalar accept", acc, 1);
    chk("R5 scalar busy set", sreg_busy, 8'h03);
    chk("R8 scalar issues next cycle", sc_issue, 1);
    @(negedge clk);
    chk("R8 scalar busy cleared", sreg_busy, 8'h00);
    chk("R12 idle after scalar", idle, 1);
  endtask

  task automatic t_vector();
    send(2'd0, 2'd0, 8'h00, 8'h06, 0);
    chk("R2 compute accept", acc, 1);
    chk("R6 add issues", {vc_issue, vc_unit}, 3'b100);
    chk("R5 vector busy set", vreg_busy, 8'h06);
    @(negedge clk);
    chk("R9 busy held while unit runs", vreg_busy, 8'h06);
    chk("R12 not idle", idle, 0);
    send(2'd0, 2'd0, 8'h00, 8'h08, 0);
    chk("R6 second add accepted", acc, 1);
    chk("R6 head waits on busy adder", vc_issue, 0);
    send(2'd1, 2'd0, 8'h00, 8'h02, 0);
    chk("R4 hazard refused", acc, 0);
    chk("R4 fetch hold", hold, 1);
    chk("R4 busy unchanged", vreg_busy, 8'h0E);
    send(2'd3, 2'd0, 8'h80, 8'h00, 0);
    chk("R2 code 3 refused", acc, 0);
    chk("R2 code 3 no busy", sreg_busy, 8'h00);
    pulse(5'b00100);
    chk("R9 done on idle divider ignored", vreg_busy, 8'h0E);
    pulse(5'b00001);
    chk("R9 adder done clears", vreg_busy, 8'h08);
    chk("R6 waiting add issues", {vc_issue, vc_unit}, 3'b100);
    @(negedge clk);
    pulse(5'b00001);
    chk("R9 second clear", vreg_busy, 8'h00);
    chk("R12 idle after drain", idle, 1);
  endtask

  task automatic t_mem_full();
    send(2'd1, 2'd0, 8'h00, 8'h01, 0);
    chk("R7 mem issues", vm_issue, 1);
    @(negedge clk);
    send(2'd1, 2'd0, 8'h00, 8'h02, 0);
    chk("R7 waits behind busy unit", vm_issue, 0);
    send(2'd1, 2'd0, 8'h00, 8'h04, 0);
    chk("R3 mem second entry", acc, 1);
    send(2'd1, 2'd0, 8'h00, 8'h08, 0);
    chk("R3 mem full refused", acc, 0);
    chk("R3 full hold", hold, 1);
    send(2'd0, 2'd1, 8'h00, 8'h10, 0);
    chk("R3 other queue still admits", acc, 1);
    pulse(5'b10000);
    chk("R9 mem done clears", vreg_busy & 8'h0F, 8'h06);
    chk("R7 next mem issues", vm_issue, 1);
    @(negedge clk);
    send(2'd1, 2'd0, 8'h00, 8'h08, 0);
    chk("R3 room after pop", acc, 1);
    drain();
    chk("R12 idle after mem drain", idle, 1);
  endtask

  task automatic t_cmp_full();
    send(2'd0, 2'd2, 8'h00, 8'h01, 0);
    @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      send(2'd0, 2'd2, 8'h00, 8'(1 << i), 0);
      chk("R3 compute fill", acc, 1);
    end
    send(2'd0, 2'd2, 8'h00, 8'h20, 0);
    chk("R3 compute full refused", acc, 0);
    send(2'd2, 2'd0, 8'h01, 8'h00, 0);
    chk("R3 scalar unaffected", acc, 1);
    drain();
    chk("R12 idle after compute drain", idle, 1);
  endtask

  task automatic t_triple();
    send(2'd0, 2'd0, 8'h00, 8'h01, 0);
    @(negedge clk);
    send(2'd1, 2'd0, 8'h00, 8'h02, 0);
    @(negedge clk);
    send(2'd0, 2'd0, 8'h00, 8'h04, 0);
    send(2'd1, 2'd0, 8'h00, 8'h08, 0);
    chk("R10 heads waiting", {vc_issue, vm_issue}, 2'b00);
    @(negedge clk);
    unit_done = 5'b10001;
    dec_valid = 1'b1; dec_queue = 2'd2; dec_sregs = 8'h04; dec_vregs = '0;
    #1;
    chk("R10 scalar accepted", dec_accept, 1);
    @(negedge clk);
    unit_done = '0; dec_valid = 1'b0; dec_sregs = '0;
    chk("R10 three issues", {vc_issue, vm_issue, sc_issue}, 3'b111);
    chk("R9 two units cleared", vreg_busy, 8'h0C);
    drain();
    chk("R12 idle after triple", idle, 1);
  endtask

  task automatic t_halt();
    send(2'd2, 2'd0, 8'h00, 8'h00, 1);
    chk("R11 halt refused", acc, 0);
    chk("R11 halt hold", hold, 1);
    chk("R11 halted", halted, 1);
    send(2'd2, 2'd0, 8'h01, 8'h00, 0);
    chk("R11 refused when halted", acc, 0);
    chk("R11 no busy after halt", sreg_busy, 8'h00);
    chk("R11 hold persists", fetch_hold, 1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scalar();
    t_vector();
    t_mem_full();
    t_cmp_full();
    t_triple();
    t_halt();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule